// File: doc/BRIEF.md
# Translation Completion Rule Checker

This block watches the two directions of address-translation traffic on a device link. Outgoing translation requests arrive as pre-decoded header fields. The block records each one in a table indexed by its tag. The entry holds the request's relaxed-ordering bit and its process-address-space attributes: the valid flag, the space identifier, and the privileged and execute flags.

Returning translation completions also arrive as pre-decoded fields. Each one is looked up by tag and checked against a small set of protocol rules. The rules cover a matching outstanding request, the presence of the trailing extension header doubleword where it is mandatory, the relaxed-ordering permission, and the echo of the address-space attributes. The outcome comes out one cycle later as a result strobe and a one-hot error vector.

A request counts as a translation request only when its address-type field holds the translation-request code. Any other request, such as a plain memory read, leaves the table untouched. A completion that finds its tag outstanding retires the entry, whatever its rule outcome. Translated-address payload decoding and timeout handling belong elsewhere.

Top module: `tcpl_rule_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, chk_vld is 0 and chk_err is all zero. Reset leaves no request outstanding.
- R2: A request is recorded only when req_at equals 2'b01 (translation request). Requests with req_at of 2'b00 or 2'b10 are ignored, so a later completion for that tag reports the unknown-tag error.
- R3: A completion whose tag has no outstanding translation request sets chk_err bit 0 (unknown tag).
- R4: A completion without data (cpl_has_data = 0) that lacks the extension doubleword (cpl_ext_dw = 0) sets chk_err bit 1. With the doubleword present, no such error is raised.
- R5: A completion whose cpl_lo_addr is not 2'b00 and that lacks the extension doubleword sets chk_err bit 2. With the doubleword present, no such error is raised.
- R6: A completion with cpl_ro = 1 whose request had req_ro = 0 sets chk_err bit 3. cpl_ro = 0 is always allowed, and cpl_ro = 1 is allowed when the request set it.
- R7: chk_err bit 4 flags an attribute mismatch. This happens when the completion's PASID-valid flag differs from the request's. It also happens when both are valid and the PASID value, the privileged flag or the execute flag differ. When neither is valid, the privileged and execute flags are not compared.
- R8: chk_vld pulses for exactly one cycle, one clock after each cpl_vld cycle. chk_err is then either zero (clean) or holds the single lowest-numbered failing rule bit. Outside those cycles chk_err is zero.
- R9: A completion whose tag is outstanding retires that entry whatever its rule outcome. A second completion for the same tag reports the unknown-tag error.
- R10: A new translation request to a tag that is already outstanding replaces the stored entry, so the latest request governs.
- R11: When a request and a completion for the same tag occur in the same cycle, the completion is checked against the previously stored entry. The new request then stays outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request header strobe |
| req_tag | input | TAG_W | Request tag |
| req_at | input | 2 | Address-type field (2'b01 = translation request) |
| req_ro | input | 1 | Request relaxed-ordering bit |
| req_pasid_vld | input | 1 | Request carries an address-space identifier |
| req_pasid | input | PASID_W | Request address-space identifier |
| req_priv | input | 1 | Request privileged-mode flag |
| req_exe | input | 1 | Request execute flag |
| cpl_vld | input | 1 | Completion header strobe |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_ro | input | 1 | Completion relaxed-ordering bit |
| cpl_has_data | input | 1 | Completion carries data (0 = unsuccessful) |
| cpl_lo_addr | input | 2 | Completion lower address bits [1:0] |
| cpl_ext_dw | input | 1 | Extension header doubleword present |
| cpl_pasid_vld | input | 1 | Completion carries an address-space identifier |
| cpl_pasid | input | PASID_W | Completion address-space identifier |
| cpl_priv | input | 1 | Completion privileged-mode flag |
| cpl_exe | input | 1 | Completion execute flag |
| chk_vld | output | 1 | Result strobe, one cycle after a completion |
| chk_err | output | 5 | One-hot failing rule: bit0 unknown tag, bit1 no-data without extension, bit2 lower address without extension, bit3 ordering, bit4 attributes |

## Verification
Completions are sent after each kind of request: non-translation address types, clean translation requests, requests with and without relaxed ordering, and requests with and without address-space attributes. This separates table admission from rule evaluation. Each rule is exercised on both its failing and its passing side, for example a missing extension doubleword next to a present one, and a mismatched identifier next to flags that are ignored. This shows that each error bit responds to its own condition alone. Completions that break several rules at once expose the priority order. Repeated completions, overwriting requests and a same-cycle request and completion on one tag distinguish the retire and update ordering of the table.

// File: rtl/tcpl_pkg.sv
package tcpl_pkg;

    parameter int PASID_W = 20;

    // rule indices, lowest index has priority
    localparam int RULE_UNEXP   = 0;
    localparam int RULE_NODATA  = 1;
    localparam int RULE_LOADDR  = 2;
    localparam int RULE_RO      = 3;
    localparam int RULE_ATTR    = 4;
    localparam int NUM_RULES    = 5;

    localparam logic [1:0] AT_XLATE_REQ = 2'b01;

    typedef struct packed {
        logic               pv;
        logic [PASID_W-1:0] pasid;
        logic               priv;
        logic               exe;
    } attr_t;

    typedef struct packed {
        logic  vld;
        logic  ro;
        attr_t attr;
    } entry_t;

    typedef struct packed {
        logic                 vld;
        logic [NUM_RULES-1:0] err;
    } result_t;

endpackage

// File: rtl/tcpl_req_decode.sv
module tcpl_req_decode
    import tcpl_pkg::*;
(
    input  logic               req_vld_i,
    input  logic [1:0]         req_at_i,
    input  logic               req_ro_i,
    input  logic               req_pasid_vld_i,
    input  logic [PASID_W-1:0] req_pasid_i,
    input  logic               req_priv_i,
    input  logic               req_exe_i,
    output logic               wr_en_o,
    output entry_t             wr_ent_o
);

    // only translation requests enter the table; ordinary reads pass by
    always_comb begin
        wr_en_o             = req_vld_i && (req_at_i == AT_XLATE_REQ);
        wr_ent_o.vld        = 1'b1;
        wr_ent_o.ro         = req_ro_i;
        wr_ent_o.attr.pv    = req_pasid_vld_i;
        wr_ent_o.attr.pasid = req_pasid_i;
        wr_ent_o.attr.priv  = req_priv_i;
        wr_ent_o.attr.exe   = req_exe_i;
    end

endmodule

// File: rtl/tcpl_req_table.sv
module tcpl_req_table
    import tcpl_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  entry_t           wr_ent_i,
    input  logic             clr_en_i,
    input  logic [TAG_W-1:0] clr_tag_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output entry_t           rd_ent_o
);

    localparam int DEPTH = 1 << TAG_W;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } table_t;

    table_t tbl_d, tbl_q;

    // retire first, then write: a same-cycle request on the retired tag survives
    always_comb begin
        tbl_d = tbl_q;
        if (clr_en_i) begin
            tbl_d.ent[clr_tag_i].vld = 1'b0;
        end
        if (wr_en_i) begin
            tbl_d.ent[wr_tag_i] = wr_ent_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ent_o = tbl_q.ent[rd_tag_i];

endmodule

// File: rtl/tcpl_rule_eval.sv
module tcpl_rule_eval
    import tcpl_pkg::*;
(
    input  entry_t               ent_i,
    input  logic                 cpl_ro_i,
    input  logic                 cpl_has_data_i,
    input  logic [1:0]           cpl_lo_addr_i,
    input  logic                 cpl_ext_dw_i,
    input  attr_t                cpl_attr_i,
    output logic [NUM_RULES-1:0] err_o
);

    logic [NUM_RULES-1:0] raw;
    logic                 attr_bad;

    always_comb begin
        attr_bad = (ent_i.attr.pv != cpl_attr_i.pv);
        if (ent_i.attr.pv && cpl_attr_i.pv) begin
            attr_bad = (ent_i.attr.pasid != cpl_attr_i.pasid) ||
                       (ent_i.attr.priv  != cpl_attr_i.priv)  ||
                       (ent_i.attr.exe   != cpl_attr_i.exe);
        end
        raw              = '0;
        raw[RULE_UNEXP]  = !ent_i.vld;
        raw[RULE_NODATA] = !cpl_has_data_i && !cpl_ext_dw_i;
        raw[RULE_LOADDR] = (cpl_lo_addr_i != 2'b00) && !cpl_ext_dw_i;
        raw[RULE_RO]     = cpl_ro_i && !ent_i.ro;
        raw[RULE_ATTR]   = attr_bad;
    end

    // keep only the lowest-numbered failing rule
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_prio
        if (g == 0) begin : g_first
            assign err_o[g] = raw[g];
        end else begin : g_rest
            assign err_o[g] = raw[g] && !(|raw[g-1:0]);
        end
    end

endmodule

// File: rtl/tcpl_rule_chk.sv
module tcpl_rule_chk
    import tcpl_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [1:0]           req_at,
    input  logic                 req_ro,
    input  logic                 req_pasid_vld,
    input  logic [PASID_W-1:0]   req_pasid,
    input  logic                 req_priv,
    input  logic                 req_exe,
    input  logic                 cpl_vld,
    input  logic [TAG_W-1:0]     cpl_tag,
    input  logic                 cpl_ro,
    input  logic                 cpl_has_data,
    input  logic [1:0]           cpl_lo_addr,
    input  logic                 cpl_ext_dw,
    input  logic                 cpl_pasid_vld,
    input  logic [PASID_W-1:0]   cpl_pasid,
    input  logic                 cpl_priv,
    input  logic                 cpl_exe,
    output logic                 chk_vld,
    output logic [NUM_RULES-1:0] chk_err
);

    logic                 wr_en;
    entry_t               wr_ent;
    entry_t               rd_ent;
    logic                 clr_en;
    attr_t                cpl_attr;
    logic [NUM_RULES-1:0] rule_err;
    result_t              res_d, res_q;

    tcpl_req_decode i_dec (
        .req_vld_i       (req_vld),
        .req_at_i        (req_at),
        .req_ro_i        (req_ro),
        .req_pasid_vld_i (req_pasid_vld),
        .req_pasid_i     (req_pasid),
        .req_priv_i      (req_priv),
        .req_exe_i       (req_exe),
        .wr_en_o         (wr_en),
        .wr_ent_o        (wr_ent)
    );

    tcpl_req_table #(.TAG_W(TAG_W)) i_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_tag_i  (req_tag),
        .wr_ent_i  (wr_ent),
        .clr_en_i  (clr_en),
        .clr_tag_i (cpl_tag),
        .rd_tag_i  (cpl_tag),
        .rd_ent_o  (rd_ent)
    );

    always_comb begin
        cpl_attr.pv    = cpl_pasid_vld;
        cpl_attr.pasid = cpl_pasid;
        cpl_attr.priv  = cpl_priv;
        cpl_attr.exe   = cpl_exe;
    end

    tcpl_rule_eval i_eval (
        .ent_i          (rd_ent),
        .cpl_ro_i       (cpl_ro),
        .cpl_has_data_i (cpl_has_data),
        .cpl_lo_addr_i  (cpl_lo_addr),
        .cpl_ext_dw_i   (cpl_ext_dw),
        .cpl_attr_i     (cpl_attr),
        .err_o          (rule_err)
    );

    // any completion that finds its tag outstanding retires it
    assign clr_en = cpl_vld && rd_ent.vld;

    always_comb begin
        res_d.vld = cpl_vld;
        res_d.err = cpl_vld ? rule_err : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign chk_vld = res_q.vld;
    assign chk_err = res_q.err;

endmodule

// File: rtl/tcpl_rule_chk_sva.sv
module tcpl_rule_chk_sva
    import tcpl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpl_vld,
    input logic                 cpl_ro,
    input logic                 cpl_has_data,
    input logic [1:0]           cpl_lo_addr,
    input logic                 cpl_ext_dw,
    input logic                 chk_vld,
    input logic [NUM_RULES-1:0] chk_err
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !chk_vld && (chk_err == '0));

    a_r8_result_follows_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld |=> chk_vld);

    a_r8_no_result_without_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        !cpl_vld |=> !chk_vld);

    a_r8_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> $onehot0(chk_err));

    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |-> (chk_err == '0));

    a_r4_nodata_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld && !cpl_has_data && !cpl_ext_dw |=>
            chk_err[RULE_UNEXP] || chk_err[RULE_NODATA]);

    a_r5_loaddr_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld && cpl_has_data && (cpl_lo_addr != 2'b00) && !cpl_ext_dw |=>
            chk_err[RULE_UNEXP] || chk_err[RULE_LOADDR]);

    a_r6_ro_clear_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld && !cpl_ro |=> !chk_err[RULE_RO]);

endmodule

bind tcpl_rule_chk tcpl_rule_chk_sva i_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpl_vld      (cpl_vld),
    .cpl_ro       (cpl_ro),
    .cpl_has_data (cpl_has_data),
    .cpl_lo_addr  (cpl_lo_addr),
    .cpl_ext_dw   (cpl_ext_dw),
    .chk_vld      (chk_vld),
    .chk_err      (chk_err)
);

// File: tb/test_tcpl_rule_chk.sv
`timescale 1ns/1ps
module test_tcpl_rule_chk;
    import tcpl_pkg::*;

    localparam int TW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_vld = 1'b0;
    logic [TW-1:0]      req_tag = '0;
    logic [1:0]         req_at = 2'b00;
    logic               req_ro = 1'b0;
    logic               req_pasid_vld = 1'b0;
    logic [PASID_W-1:0] req_pasid = '0;
    logic               req_priv = 1'b0;
    logic               req_exe = 1'b0;
    logic               cpl_vld = 1'b0;
    logic [TW-1:0]      cpl_tag = '0;
    logic               cpl_ro = 1'b0;
    logic               cpl_has_data = 1'b1;
    logic [1:0]         cpl_lo_addr = 2'b00;
    logic               cpl_ext_dw = 1'b0;
    logic               cpl_pasid_vld = 1'b0;
    logic [PASID_W-1:0] cpl_pasid = '0;
    logic               cpl_priv = 1'b0;
    logic               cpl_exe = 1'b0;
    logic               chk_vld;
    logic [NUM_RULES-1:0] chk_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NUM_RULES-1:0] exp_q[$];
    string                tag_q[$];

    always #2 clk = ~clk;

    tcpl_rule_chk #(.TAG_W(TW)) i_tcpl_rule_chk (.*);

    task automatic check(input string rq, input logic [NUM_RULES-1:0] act,
                         input logic [NUM_RULES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    // monitor: pops one expectation per result strobe
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (chk_vld) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: actual unexpected result %b expected none", chk_err);
                end else begin
                    check(tag_q.pop_front(), chk_err, exp_q.pop_front());
                end
            end else begin
                check("R8 idle err", chk_err, '0);
            end
        end
    end

    task automatic set_req(input logic [TW-1:0] t, input logic [1:0] at, input logic ro,
                           input logic pv, input logic [PASID_W-1:0] p,
                           input logic pr, input logic ex);
        req_vld = 1'b1; req_tag = t; req_at = at; req_ro = ro;
        req_pasid_vld = pv; req_pasid = p; req_priv = pr; req_exe = ex;
    endtask

    task automatic set_cpl(input logic [TW-1:0] t, input logic ro, input logic dat,
                           input logic [1:0] lo, input logic ext, input logic pv,
                           input logic [PASID_W-1:0] p, input logic pr, input logic ex,
                           input logic [NUM_RULES-1:0] exp, input string rq);
        cpl_vld = 1'b1; cpl_tag = t; cpl_ro = ro; cpl_has_data = dat;
        cpl_lo_addr = lo; cpl_ext_dw = ext; cpl_pasid_vld = pv; cpl_pasid = p;
        cpl_priv = pr; cpl_exe = ex;
        exp_q.push_back(exp);
        tag_q.push_back(rq);
    endtask

    task automatic tick();
        @(negedge clk);
        req_vld = 1'b0;
        cpl_vld = 1'b0;
    endtask

    task automatic req(input logic [TW-1:0] t, input logic [1:0] at, input logic ro,
                       input logic pv, input logic [PASID_W-1:0] p,
                       input logic pr, input logic ex);
        set_req(t, at, ro, pv, p, pr, ex);
        tick();
    endtask

    task automatic cpl(input logic [TW-1:0] t, input logic ro, input logic dat,
                       input logic [1:0] lo, input logic ext, input logic pv,
                       input logic [PASID_W-1:0] p, input logic pr, input logic ex,
                       input logic [NUM_RULES-1:0] exp, input string rq);
        set_cpl(t, ro, dat, lo, ext, pv, p, pr, ex, exp, rq);
        tick();
    endtask

    localparam logic [NUM_RULES-1:0] OK   = 5'b00000;
    localparam logic [NUM_RULES-1:0] E_UN = 5'b00001;
    localparam logic [NUM_RULES-1:0] E_ND = 5'b00010;
    localparam logic [NUM_RULES-1:0] E_LA = 5'b00100;
    localparam logic [NUM_RULES-1:0] E_RO = 5'b01000;
    localparam logic [NUM_RULES-1:0] E_AT = 5'b10000;
    localparam logic [PASID_W-1:0] PA = 20'h12345;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (chk_vld !== 1'b0 || chk_err !== '0) begin
            errors++;
            $display("FAIL R1: actual %b/%b expected 0/0", chk_vld, chk_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (chk_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 0 after release", chk_vld);
        end

        // R1, R3: empty table
        cpl(4'd3, 0, 1, 2'b00, 0, 0, '0, 0, 0, E_UN, "R1/R3 empty table");
        // R2: non-translation address types ignored
        req(4'd1, 2'b00, 0, 0, '0, 0, 0);
        cpl(4'd1, 0, 1, 2'b00, 0, 0, '0, 0, 0, E_UN, "R2 at=00 ignored");
        req(4'd2, 2'b10, 0, 0, '0, 0, 0);
        cpl(4'd2, 0, 1, 2'b00, 0, 0, '0, 0, 0, E_UN, "R2 at=10 ignored");
        // R8 clean, R9 retire
        req(4'd5, 2'b01, 0, 0, '0, 0, 0);
        cpl(4'd5, 0, 1, 2'b00, 0, 0, '0, 0, 0, OK, "R8 clean completion");
        cpl(4'd5, 0, 1, 2'b00, 0, 0, '0, 0, 0, E_UN, "R9 retired tag");
        // R4
        req(4'd6, 2'b01, 0, 0, '0, 0, 0);
        req(4'd7, 2'b01, 0, 0, '0, 0, 0);
        cpl(4'd6, 0, 0, 2'b00, 0, 0, '0, 0, 0, E_ND, "R4 no data without ext");
        cpl(4'd7, 0, 0, 2'b00, 1, 0, '0, 0, 0, OK, "R4 no data with ext");
        // R9: errored completion also retires
        cpl(4'd6, 0, 1, 2'b00, 0, 0, '0, 0, 0, E_UN, "R9 errored completion retired");
        // R5
        req(4'd8, 2'b01, 0, 0, '0, 0, 0);
        req(4'd9, 2'b01, 0, 0, '0, 0, 0);
        cpl(4'd8, 0, 1, 2'b10, 0, 0, '0, 0, 0, E_LA, "R5 lo addr without ext");
        cpl(4'd9, 0, 1, 2'b01, 1, 0, '0, 0, 0, OK, "R5 lo addr with ext");
        // R6
        req(4'd9, 2'b01, 0, 0, '0, 0, 0);
        req(4'd10, 2'b01, 1, 0, '0, 0, 0);
        cpl(4'd9, 1, 1, 2'b00, 0, 0, '0, 0, 0, E_RO, "R6 ro not permitted");
        cpl(4'd10, 1, 1, 2'b00, 0, 0, '0, 0, 0, OK, "R6 ro permitted");
        // R7
        req(4'd11, 2'b01, 0, 1, PA, 1, 0);
        req(4'd12, 2'b01, 0, 1, PA, 1, 0);
        req(4'd13, 2'b01, 0, 1, PA, 1, 0);
        req(4'd14, 2'b01, 0, 1, PA, 1, 0);
        req(4'd15, 2'b01, 0, 0, '0, 0, 0);
        req(4'd0, 2'b01, 0, 0, '0, 1, 1);
        cpl(4'd11, 0, 1, 2'b00, 0, 1, PA, 1, 0, OK, "R7 attributes echoed");
        cpl(4'd12, 0, 1, 2'b00, 0, 1, PA ^ 20'h1, 1, 0, E_AT, "R7 pasid differs");
        cpl(4'd13, 0, 1, 2'b00, 0, 0, PA, 1, 0, E_AT, "R7 pasid dropped");
        cpl(4'd14, 0, 1, 2'b00, 0, 1, PA, 1, 1, E_AT, "R7 exe differs");
        cpl(4'd15, 0, 1, 2'b00, 0, 1, PA, 0, 0, E_AT, "R7 pasid added");
        cpl(4'd0, 0, 1, 2'b00, 0, 0, '0, 0, 0, OK, "R7 flags ignored without pasid");
        // R8 priority
        req(4'd4, 2'b01, 0, 1, PA, 0, 0);
        cpl(4'd4, 1, 0, 2'b11, 0, 0, '0, 0, 0, E_ND, "R8 priority no-data first");
        cpl(4'd4, 1, 0, 2'b11, 0, 0, '0, 0, 0, E_UN, "R8 priority unknown first");
        req(4'd4, 2'b01, 0, 1, PA, 0, 0);
        cpl(4'd4, 1, 1, 2'b00, 0, 0, '0, 0, 0, E_RO, "R8 priority ro over attr");
        // R10 overwrite
        req(4'd3, 2'b01, 0, 0, '0, 0, 0);
        req(4'd3, 2'b01, 1, 0, '0, 0, 0);
        cpl(4'd3, 1, 1, 2'b00, 0, 0, '0, 0, 0, OK, "R10 latest request governs");
        // R11 same-cycle request and completion
        req(4'd2, 2'b01, 0, 0, '0, 0, 0);
        set_req(4'd2, 2'b01, 1, 0, '0, 0, 0);
        set_cpl(4'd2, 1, 1, 2'b00, 0, 0, '0, 0, 0, E_RO, "R11 checked against old entry");
        tick();
        cpl(4'd2, 1, 1, 2'b00, 0, 0, '0, 0, 0, OK, "R11 new request outstanding");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: actual %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule